// File: doc/BRIEF.md
# Capability Record Transmitter

This block answers a capability query from a host. When its request input pulses while the block is idle, it sends a fixed, self-describing record one byte at a time through a valid/ready byte handshake. The handshake normally feeds a UART transmitter. Each entry in the record starts with a key byte. The top three bits of the key give the payload format and the low five bits say which quantity follows. The payload is then either a zero-terminated ASCII string, a four-byte unsigned integer or a single byte. A zero key closes the record.

All values are fixed at elaboration by parameters: the device name, the firmware version string, the probe count, the sample memory size in bytes, the maximum sample rate in Hz and the protocol version. The block turns them into a byte table of constant length. A small sequencer steps through that table, one accepted transfer at a time.

Top module: `mdr_capability_tx`

## Requirements
- R1: While reset is held, and after it is released until a request arrives, tx_valid is low.
- R2: A request seen at a clock edge while idle raises tx_valid at that edge, and the first byte offered is the name key 0x01. A key byte carries the payload format in bits 7:5 (0 = string, 1 = 32-bit, 2 = 8-bit) and the token in bits 4:0.
- R3: Entries go out in a fixed order: name, firmware version, probe count, sample memory, maximum rate, protocol version, end. A string entry is sent as its key, then its characters from first to last, then 0x00. The name key is 0x01 and the firmware version key is 0x02.
- R4: Each 32-bit entry is sent as its key followed by four value bytes, most significant byte first. The keys are 0x20 for the probe count, 0x21 for the sample memory and 0x23 for the maximum rate.
- R5: The protocol version goes out as key 0x41 followed by one value byte.
- R6: The record ends with a 0x00 byte. tx_valid is low in the cycle after that byte is accepted.
- R7: While tx_valid is high and tx_ready is low, tx_valid stays high and tx_data holds its value. No byte is dropped or repeated, whatever the pattern of tx_ready.
- R8: A request that arrives while a record is in flight is ignored: the stream neither restarts nor changes. After the closing zero, the block stays idle until a new request, which then starts a complete new record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Capability query request |
| tx_ready | input | 1 | Downstream transmitter can take a byte |
| tx_valid | output | 1 | tx_data holds a record byte |
| tx_data | output | 8 | Record byte |

## Verification
All of the block's state is the in-flight flag and the byte index. A wrong index shows at once as a wrong byte at the next accepted transfer. It also shows as a byte that changes under back-pressure in the very cycle the index moves without a handshake. A stuck in-flight flag shows as one of two faults: tx_valid stays high past the closing zero, or a record is re-entered when a request arrives mid-stream. Either fault appears within one cycle of the event.

// File: rtl/mdr_pkg.sv
package mdr_pkg;

  typedef enum logic [2:0] {
    PT_STR = 3'd0,
    PT_U32 = 3'd1,
    PT_U8  = 3'd2
  } ptype_e;

  // key byte: format in the top three bits, token in the low five
  function automatic logic [7:0] make_key(ptype_e t, logic [4:0] tok);
    return {t, tok};
  endfunction

  // byte j of a 32-bit value, j = 0 is the most significant
  function automatic logic [7:0] u32_byte(logic [31:0] v, int j);
    return v[(3 - j) * 8 +: 8];
  endfunction

  // record length: two strings with key and terminator, three 32-bit
  // entries, one 8-bit entry, closing zero
  function automatic int record_len(int name_len, int fw_len);
    return (name_len + 2) + (fw_len + 2) + 3 * 5 + 2 + 1;
  endfunction

endpackage

// File: rtl/mdr_rom.sv
module mdr_rom
  import mdr_pkg::*;
#(
  parameter int                    NAME_LEN  = 5,
  parameter logic [NAME_LEN*8-1:0] NAME_STR  = "CAPTR",
  parameter int                    FW_LEN    = 4,
  parameter logic [FW_LEN*8-1:0]   FW_STR    = "1.04",
  parameter logic [31:0]           PROBES    = 32'd32,
  parameter logic [31:0]           MEM_BYTES = 32'd24576,
  parameter logic [31:0]           MAX_RATE  = 32'd200000000,
  parameter logic [7:0]            PROTO     = 8'd2,
  parameter int                    TOTAL     = record_len(NAME_LEN, FW_LEN),
  parameter int                    IDX_W     = $clog2(TOTAL + 1)
) (
  input  logic [IDX_W-1:0] idx,
  output logic [7:0]       data
);

  localparam int O_NAME  = 0;
  localparam int O_FW    = O_NAME + NAME_LEN + 2;
  localparam int O_PRB   = O_FW + FW_LEN + 2;
  localparam int O_MEM   = O_PRB + 5;
  localparam int O_RATE  = O_MEM + 5;
  localparam int O_PROTO = O_RATE + 5;

  function automatic logic [7:0] byte_at(int k);
    if (k == O_NAME)                return make_key(PT_STR, 5'h01);
    if (k <= O_NAME + NAME_LEN)     return NAME_STR[(NAME_LEN + O_NAME - k) * 8 +: 8];
    if (k == O_NAME + NAME_LEN + 1) return 8'h00;
    if (k == O_FW)                  return make_key(PT_STR, 5'h02);
    if (k <= O_FW + FW_LEN)         return FW_STR[(FW_LEN + O_FW - k) * 8 +: 8];
    if (k == O_FW + FW_LEN + 1)     return 8'h00;
    if (k == O_PRB)                 return make_key(PT_U32, 5'h00);
    if (k <  O_MEM)                 return u32_byte(PROBES, k - O_PRB - 1);
    if (k == O_MEM)                 return make_key(PT_U32, 5'h01);
    if (k <  O_RATE)                return u32_byte(MEM_BYTES, k - O_MEM - 1);
    if (k == O_RATE)                return make_key(PT_U32, 5'h03);
    if (k <  O_PROTO)               return u32_byte(MAX_RATE, k - O_RATE - 1);
    if (k == O_PROTO)               return make_key(PT_U8, 5'h01);
    if (k == O_PROTO + 1)           return PROTO;
    return 8'h00;
  endfunction

  logic [7:0] table_q [TOTAL];

  for (genvar k = 0; k < TOTAL; k++) begin : g_tab
    assign table_q[k] = byte_at(k);
  end

  always_comb begin
    data = 8'h00;
    for (int k = 0; k < TOTAL; k++)
      if (idx == IDX_W'(k)) data = table_q[k];
  end

endmodule

// File: rtl/mdr_seq.sv
module mdr_seq #(
  parameter int TOTAL = 31,
  parameter int IDX_W = $clog2(TOTAL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic             tx_ready,
  output logic             tx_valid,
  output logic [IDX_W-1:0] idx,
  output logic             beat,
  output logic             last_beat
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(TOTAL - 1);

  assign beat      = tx_valid & tx_ready;
  assign last_beat = beat & (idx == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      idx      <= '0;
    end else if (!tx_valid) begin
      if (start_req) begin
        tx_valid <= 1'b1;
        idx      <= '0;
      end
    end else if (last_beat) begin
      tx_valid <= 1'b0;
      idx      <= '0;
    end else if (beat) begin
      idx <= idx + 1'b1;
    end
  end

endmodule

// File: rtl/mdr_capability_tx.sv
module mdr_capability_tx
  import mdr_pkg::*;
#(
  parameter int                    NAME_LEN  = 5,
  parameter logic [NAME_LEN*8-1:0] NAME_STR  = "CAPTR",
  parameter int                    FW_LEN    = 4,
  parameter logic [FW_LEN*8-1:0]   FW_STR    = "1.04",
  parameter logic [31:0]           PROBES    = 32'd32,
  parameter logic [31:0]           MEM_BYTES = 32'd24576,
  parameter logic [31:0]           MAX_RATE  = 32'd200000000,
  parameter logic [7:0]            PROTO     = 8'd2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic       tx_ready,
  output logic       tx_valid,
  output logic [7:0] tx_data
);

  localparam int TOTAL = record_len(NAME_LEN, FW_LEN);
  localparam int IDX_W = $clog2(TOTAL + 1);

  logic [IDX_W-1:0] idx;
  logic             beat;
  logic             last_beat;

  mdr_seq #(.TOTAL(TOTAL), .IDX_W(IDX_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (req),
    .tx_ready  (tx_ready),
    .tx_valid  (tx_valid),
    .idx       (idx),
    .beat      (beat),
    .last_beat (last_beat)
  );

  mdr_rom #(
    .NAME_LEN (NAME_LEN), .NAME_STR (NAME_STR),
    .FW_LEN   (FW_LEN),   .FW_STR   (FW_STR),
    .PROBES   (PROBES),   .MEM_BYTES(MEM_BYTES),
    .MAX_RATE (MAX_RATE), .PROTO    (PROTO),
    .TOTAL    (TOTAL),    .IDX_W    (IDX_W)
  ) u_rom (
    .idx  (idx),
    .data (tx_data)
  );

endmodule

// File: rtl/mdr_capability_chk.sv
module mdr_capability_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req,
  input logic       tx_ready,
  input logic       tx_valid,
  input logic [7:0] tx_data,
  input logic       beat,
  input logic       last_beat
);

  AST_START_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_valid && req) |=> (tx_valid && tx_data == 8'h01)); // R2

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data))); // R7

  AST_END_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |-> (tx_data == 8'h00)); // R6

  AST_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |=> !tx_valid); // R6

  AST_REQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && req && !beat) |=> (tx_valid && $stable(tx_data))); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_valid && !req) |=> !tx_valid); // R1

endmodule

bind mdr_capability_tx mdr_capability_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req       (req),
  .tx_ready  (tx_ready),
  .tx_valid  (tx_valid),
  .tx_data   (tx_data),
  .beat      (beat),
  .last_beat (last_beat)
);

// File: tb/sim_mdr_capability_tx.sv
`timescale 1ns/1ps
module sim_mdr_capability_tx;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0;
  logic       tx_ready = 1'b1;
  logic       tx_valid;
  logic [7:0] tx_data;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int ready_mode = 0;
  bit finished = 1'b0;

  logic [7:0] exp_q [$];
  string      tag_q [$];

  bit         held_v = 1'b0;
  logic [7:0] held_d = 8'h00;
  bit         end_seen = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  mdr_capability_tx u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .tx_ready(tx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data)
  );

  task automatic check(bit ok, string r, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", r, act, exp);
    end
  endtask

  // scoreboard driver helpers
  task automatic push(logic [7:0] b, string r);
    exp_q.push_back(b);
    tag_q.push_back(r);
  endtask

  task automatic push_str(logic [7:0] key, string s);
    push(key, "R3");
    for (int i = 0; i < s.len(); i++) push(s[i], "R3");
    push(8'h00, "R3");
  endtask

  task automatic push_u32(logic [7:0] key, logic [31:0] v);
    push(key, "R4");
    push(v[31:24], "R4"); push(v[23:16], "R4");
    push(v[15:8], "R4");  push(v[7:0], "R4");
  endtask

  task automatic push_record();
    push_str(8'h01, "CAPTR");
    tag_q[tag_q.size() - 7] = "R2";
    push_str(8'h02, "1.04");
    push_u32(8'h20, 32'd32);
    push_u32(8'h21, 32'd24576);
    push_u32(8'h23, 32'd200000000);
    push(8'h41, "R5");
    push(8'h02, "R5");
    push(8'h00, "R6");
  endtask

  task automatic send_record();
    push_record();
    @(posedge clk); #1 req = 1'b1;
    @(posedge clk); #1 req = 1'b0;
    @(negedge clk);
    check(tx_valid === 1'b1, "R2 valid after request", int'(tx_valid), 1);
  endtask

  task automatic wait_done();
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while ((exp_q.size() != 0 || tx_valid) && n < 5000);
    check(exp_q.size() == 0, "R3 record completed", exp_q.size(), 0);
  endtask

  // ready pattern generator
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1;
    case (ready_mode)
      0: tx_ready = 1'b1;
      1: tx_ready = (cyc % 3) != 0;
      default: tx_ready = (cyc % 5) == 0;
    endcase
  end

  // monitor: compares accepted bytes and stall behaviour
  always @(negedge clk) begin
    if (rst_n) begin
      if (end_seen)
        check(tx_valid === 1'b0, "R6 valid low after end", int'(tx_valid), 0);
      end_seen = 1'b0;
      if (held_v)
        check(tx_valid === 1'b1 && tx_data === held_d, "R7 held under stall",
              int'(tx_data), int'(held_d));
      held_v = tx_valid && !tx_ready;
      held_d = tx_data;
      if (tx_valid && tx_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8 unexpected byte", int'(tx_data), 0);
        end else begin
          logic [7:0] e;
          string r;
          e = exp_q.pop_front();
          r = tag_q.pop_front();
          check(tx_data === e, r, int'(tx_data), int'(e));
          if (r == "R6") end_seen = 1'b1;
        end
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 100000 && !finished) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(tx_valid === 1'b0, "R1 valid in reset", int'(tx_valid), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (4) begin
      @(negedge clk);
      check(tx_valid === 1'b0, "R1 idle after reset", int'(tx_valid), 0);
    end

    ready_mode = 0;
    send_record();
    wait_done();

    ready_mode = 1;
    send_record();
    repeat (6) @(posedge clk);
    #1 req = 1'b1;
    @(posedge clk); #1 req = 1'b0;
    repeat (3) @(posedge clk);
    #1 req = 1'b1;
    @(posedge clk); #1 req = 1'b0;
    wait_done();
    repeat (8) begin
      @(negedge clk);
      check(tx_valid === 1'b0, "R8 idle after record", int'(tx_valid), 0);
    end

    ready_mode = 2;
    send_record();
    wait_done();

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule